// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block turns a three-wire stereo PCM stream (bit clock, channel clock and serial data) into a pair of 20-bit parallel samples. It emits a one-cycle strobe once per stereo sample period. All three wires are sampled in the block's system clock domain. The bit clock must stay low and high for at least two system clock cycles each.

Three framings are accepted: right-justified 16-bit, right-justified 20-bit, and a 16-bit I2S framing with 32 bit clocks per sample period. A static input swaps which channel-clock level means left. Short words are widened to 20 bits with zero fill at the bottom.

A separate run detector watches the data bits taken on bit clock rising edges. It raises a flag when the line has held one value for a long stretch, which marks silence or a stalled source. Format, width, polarity and detector enable are static inputs, changed only while reset is held.

Top module: `serial_pcm_rx`

## Requirements
- R1: In right-justified 20-bit mode (`fmt_i2s`=0, `wide20`=1), each channel word is the last 20 bits sampled before the channel clock edge that ends that channel's half period. The first of these bits is the MSB and lands in bit 19.
- R2: In right-justified 16-bit mode (`wide20`=0), each channel word is the last 16 bits before the ending edge. These are placed in bits 19..4 and bits 3..0 read zero.
- R3: Bits sampled in a half period ahead of the word (leading padding) have no effect on the captured word.
- R4: In I2S mode (`fmt_i2s`=1), the MSB is the bit sampled one bit clock after the channel edge. The LSB is the bit sampled at the next channel edge. The word is always 16 bits, placed in bits 19..4 with bits 3..0 zero, whatever the value of `wide20`.
- R5: With `lr_swap`=0, a high channel clock marks left in right-justified mode and a low channel clock marks left in I2S mode. `lr_swap`=1 inverts the level that marks left in both modes.
- R6: `sample_valid` pulses for exactly one clock after the right word completes. `left_data` and `right_data` change together in that cycle and hold their values at all other times.
- R7: No strobe is issued for a right word unless a left word was captured after reset or after the previous strobe.
- R8: `sdata` and `lrclk` are sampled only on rising edges of `bclk`. Changes of `sdata` while `bclk` is high have no effect.
- R9: When `run_off`=0, `const_flag` rises once RUN_LEN consecutive sampled bits (default 65,536) have had the same value. This holds for a run of zeros and for a run of ones.
- R10: A run of RUN_LEN-1 equal bits leaves `const_flag` low. The flag falls at the first sampled bit that differs from the run.
- R11: With `run_off`=1, `const_flag` stays low. Tying `run_off` low leaves detection enabled, which is the default.
- R12: After reset, `left_data`, `right_data`, `sample_valid` and `const_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Channel (sample-rate) clock |
| sdata | input | 1 | Serial data, MSB first |
| fmt_i2s | input | 1 | 1 selects I2S framing, 0 selects right-justified |
| wide20 | input | 1 | 1 selects 20-bit words in right-justified mode |
| lr_swap | input | 1 | Inverts the channel clock level that marks left |
| run_off | input | 1 | 1 disables the constant-data detector |
| left_data | output | 20 | Left sample |
| right_data | output | 20 | Right sample |
| sample_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |
| const_flag | output | 1 | Input data has been constant for RUN_LEN bits |

## Verification
The hardest state to reach is the exact boundary of the run detector: RUN_LEN-1 equal bits must leave the flag low, and the next equal bit must set it. The bench overrides RUN_LEN to a small value so that this edge sits in a short bit stream. It drives single bits one at a time and checks the flag after each critical bit, for zeros and for ones.

Frame traffic goes into a scoreboard. The scoreboard fills the ignored leading bits with random junk, and it flips `sdata` while the bit clock is high. A mis-sampled or mis-aligned bit therefore shows up as a wrong word.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    localparam int unsigned SMP_W   = 20;
    localparam int unsigned SHORT_W = 16;
    localparam int unsigned PAD_W   = SMP_W - SHORT_W;
    typedef logic [SMP_W-1:0] sample_t;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_d, sig_q;

    always_comb begin
        sig_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_d;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/pcm_word_asm.sv
module pcm_word_asm
    import pcm_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    lr,
    input  logic    sd,
    input  logic    i2s,
    input  logic    wide,
    input  logic    swap,
    output sample_t left_o,
    output sample_t right_o,
    output logic    valid_o
);
    typedef struct packed {
        sample_t shreg;
        logic    lr_prev;
        logic    primed;
        logic    left_seen;
        sample_t left_pend;
        sample_t left_out;
        sample_t right_out;
        logic    valid;
    } asm_st_t;

    asm_st_t st_d, st_q;
    sample_t word;
    logic    left_lvl;

    always_comb begin
        left_lvl = ~(swap ^ i2s);
        if (i2s)
            word = {st_q.shreg[SHORT_W-2:0], sd, {PAD_W{1'b0}}};
        else if (wide)
            word = st_q.shreg;
        else
            word = {st_q.shreg[SHORT_W-1:0], {PAD_W{1'b0}}};

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (tick) begin
            st_d.shreg   = {st_q.shreg[SMP_W-2:0], sd};
            st_d.lr_prev = lr;
            st_d.primed  = 1'b1;
            if (st_q.primed && (lr != st_q.lr_prev)) begin
                if (st_q.lr_prev == left_lvl) begin
                    st_d.left_pend = word;
                    st_d.left_seen = 1'b1;
                end else if (st_q.left_seen) begin
                    st_d.left_out  = st_q.left_pend;
                    st_d.right_out = word;
                    st_d.valid     = 1'b1;
                    st_d.left_seen = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.left_out;
    assign right_o = st_q.right_out;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/pcm_run_det.sv
module pcm_run_det #(
    parameter int unsigned RUN_LEN = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sd,
    input  logic off,
    output logic flag
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if ((st_q.cnt != '0) && (sd == st_q.last))
                st_d.cnt = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
            else
                st_d.cnt = {{(CNT_W-1){1'b0}}, 1'b1};
            st_d.last = sd;
        end
        st_d.flag = ~off && (st_d.cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int unsigned RUN_LEN = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             lrclk,
    input  logic             sdata,
    input  logic             fmt_i2s,
    input  logic             wide20,
    input  logic             lr_swap,
    input  logic             run_off,
    output logic [SMP_W-1:0] left_data,
    output logic [SMP_W-1:0] right_data,
    output logic             sample_valid,
    output logic             const_flag
);
    logic bit_tick;

    pcm_edge_det u_bedge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (bclk),
        .rise  (bit_tick)
    );

    pcm_word_asm u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .lr      (lrclk),
        .sd      (sdata),
        .i2s     (fmt_i2s),
        .wide    (wide20),
        .swap    (lr_swap),
        .left_o  (left_data),
        .right_o (right_data),
        .valid_o (sample_valid)
    );

    pcm_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .sd    (sdata),
        .off   (run_off),
        .flag  (const_flag)
    );
endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bclk,
    input logic        fmt_i2s,
    input logic        wide20,
    input logic        run_off,
    input logic [19:0] left_data,
    input logic [19:0] right_data,
    input logic        sample_valid,
    input logic        const_flag
);
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_data) && $stable(right_data)));

    // R4 shares this check: I2S words carry zero low nibbles
    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (!wide20 || fmt_i2s)) |-> (left_data[3:0] == 4'h0 && right_data[3:0] == 4'h0));

    assert_flag_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run_off |=> !const_flag);

    assert_valid_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> ($past(bclk) && !$past(bclk, 2)));
endmodule

bind serial_pcm_rx pcm_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk         (bclk),
    .fmt_i2s      (fmt_i2s),
    .wide20       (wide20),
    .run_off      (run_off),
    .left_data    (left_data),
    .right_data   (right_data),
    .sample_valid (sample_valid),
    .const_flag   (const_flag)
);

// File: tb/sim_serial_pcm_rx.sv
module sim_serial_pcm_rx;
    localparam int unsigned RL = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic fmt_i2s = 1'b0, wide20 = 1'b1, lr_swap = 1'b0, run_off = 1'b0;
    logic [19:0] left_data, right_data;
    logic sample_valid, const_flag;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    string cur_req = "R1";
    logic [39:0] exp_q[$];
    logic pend_lsb = 1'b0;

    always #2 clk = ~clk;

    serial_pcm_rx #(.RUN_LEN(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .fmt_i2s(fmt_i2s), .wide20(wide20), .lr_swap(lr_swap), .run_off(run_off),
        .left_data(left_data), .right_data(right_data),
        .sample_valid(sample_valid), .const_flag(const_flag)
    );

    function automatic logic left_lvl();
        return ~(lr_swap ^ fmt_i2s);
    endfunction

    function automatic logic [19:0] exp_word(input logic [19:0] w);
        if (fmt_i2s || !wide20) return {w[15:0], 4'h0};
        return w;
    endfunction

    task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            vcount++;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7 unexpected strobe got %h_%h expected none", left_data, right_data);
            end else begin
                check(cur_req, {left_data, right_data}, exp_q.pop_front());
            end
        end
    end

    // one bit per call; sdata flipped while bclk is high (R8)
    task automatic bit_out(input logic lr, input logic b);
        @(negedge clk); bclk = 1'b0; lrclk = lr; sdata = b;
        @(negedge clk);
        @(negedge clk); bclk = 1'b1;
        @(negedge clk); sdata = ~b;
    endtask

    task automatic send_half(input logic lr, input logic [19:0] w);
        if (fmt_i2s) begin
            for (int j = 0; j < 16; j++)
                bit_out(lr, (j == 0) ? pend_lsb : w[16-j]);
            pend_lsb = w[0];
        end else begin
            int wd;
            wd = wide20 ? 20 : 16;
            for (int j = 0; j < 24; j++) begin
                if (j < 24 - wd) bit_out(lr, 1'($urandom % 2)); // R3 junk
                else             bit_out(lr, w[wd-1-(j-(24-wd))]);
            end
        end
    endtask

    task automatic send_frame(input logic [19:0] l, input logic [19:0] r);
        exp_q.push_back({exp_word(l), exp_word(r)});
        send_half(left_lvl(), l);
        send_half(~left_lvl(), r);
    endtask

    task automatic do_reset(input logic i2s, input logic w20, input logic sw, input string req);
        rst_n = 1'b0;
        fmt_i2s = i2s; wide20 = w20; lr_swap = sw; run_off = 1'b0;
        bclk = 1'b0; sdata = 1'b0; lrclk = ~left_lvl(); pend_lsb = 1'b0;
        cur_req = req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send_half(~left_lvl(), 20'h5A5A5); // preamble right half, no strobe (R7)
    endtask

    task automatic finish_run();
        send_half(left_lvl(), 20'h00000);
        repeat (8) @(negedge clk);
        check({cur_req, " drain"}, 40'(exp_q.size()), 40'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12", {left_data, right_data}, 40'd0);
        check("R12", {38'd0, sample_valid, const_flag}, 40'd0);
        rst_n = 1'b1;

        // R1 R3 R8: right-justified 20-bit
        do_reset(1'b0, 1'b1, 1'b0, "R1");
        send_frame(20'hABCDE, 20'h12345);
        send_frame(20'hFFFFF, 20'h00000);
        send_frame(20'h80001, 20'h7FFFE);
        finish_run();

        // R2: 16-bit zero padding
        do_reset(1'b0, 1'b0, 1'b0, "R2");
        send_frame(20'h0F00F, 20'h0A5C3);
        send_frame(20'h08000, 20'h07FFF);
        finish_run();

        // R5: polarity swap, right-justified
        do_reset(1'b0, 1'b1, 1'b1, "R5");
        send_frame(20'h13579, 20'hECA86);
        send_frame(20'h00001, 20'h80000);
        finish_run();

        // R4: I2S, 20-bit request treated as 16
        do_reset(1'b1, 1'b1, 1'b0, "R4");
        send_frame(20'h0C001, 20'h08003);
        send_frame(20'h0FFFF, 20'h01234);
        finish_run();
        do_reset(1'b1, 1'b0, 1'b0, "R4");
        send_frame(20'h0BEEF, 20'h0CAFE);
        finish_run();

        // R5: polarity swap, I2S
        do_reset(1'b1, 1'b0, 1'b1, "R5");
        send_frame(20'h01357, 20'h09BDF);
        finish_run();

        // R7: a left word alone yields no strobe
        do_reset(1'b0, 1'b1, 1'b0, "R7");
        begin
            int v0;
            v0 = vcount;
            send_half(left_lvl(), 20'h11111);
            send_half(~left_lvl(), 20'h22222);
            repeat (8) @(negedge clk);
            check("R7", 40'(vcount - v0), 40'd0);
        end

        // R9 R10 R11: constant-run detector
        do_reset(1'b0, 1'b1, 1'b0, "R9");
        for (int i = 0; i < RL - 1; i++) bit_out(1'b0, 1'b0);
        check("R10 short run", 40'(const_flag), 40'd0);
        bit_out(1'b0, 1'b0);
        check("R9 zeros", 40'(const_flag), 40'd1);
        bit_out(1'b0, 1'b1);
        check("R10 clear", 40'(const_flag), 40'd0);
        for (int i = 0; i < RL - 1; i++) bit_out(1'b0, 1'b1);
        check("R9 ones", 40'(const_flag), 40'd1);
        run_off = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 off", 40'(const_flag), 40'd0);
        for (int i = 0; i < RL + 40; i++) bit_out(1'b0, 1'b1);
        check("R11 held", 40'(const_flag), 40'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule